// File: doc/BRIEF.md
# Threshold-Interrupt Receive FIFO

This block buffers bytes that a serial bus controller's byte engine receives, so that a host can collect them later. The engine offers one byte per cycle on a push strobe. The host reaches the block through a small register port with a 2-bit address. A read at the data address removes the oldest byte. A read at the fill-level address returns the number of stored bytes minus one. The threshold address can be both written and read.

The block raises a level interrupt request once the FIFO holds more bytes than the programmed threshold. A threshold of N therefore requests service when N+1 bytes are waiting. Typical host software sets the threshold to the smaller of (bytes still expected minus one) and (depth minus one). When the request arrives, it reads the whole burst and then sets the threshold again for the next burst. Empty and full flags are provided as well. A sticky overflow flag records bytes that were lost, and a synchronous flush input discards everything stored.

Top module: `rxq_top`

## Requirements
- R1: After reset, rx_empty=1, rx_full=0, rx_level_irq=0, rx_overflow=0 and host_rdata=0. A read of the fill level (address 1) returns 0, and a read of the threshold (address 2) returns 0.
- R2: Bytes leave in the order they arrived. A host read at address 0 with a non-empty FIFO removes the oldest byte, and that byte appears on host_rdata one clock after the read strobe.
- R3: A push while 16 bytes are stored is dropped, even if a pop happens in the same cycle. It sets rx_overflow one clock later, and rx_overflow stays set until a flush or a reset.
- R4: A read at address 0 while the FIFO is empty leaves host_rdata at its previous value and changes no stored state.
- R5: A read at address 1 returns the stored count minus one in bits [3:0], with zeros above. It returns 0 when the FIFO is empty.
- R6: A write at address 2 stores host_wdata[3:0] as the threshold. A read at address 2 returns the threshold in bits [3:0], with zeros above. A read at address 3 returns 0.
- R7: rx_level_irq is 1 exactly when the stored count is at least threshold+1, and it follows the count and the threshold one clock after they change.
- R8: rx_empty is 1 exactly when no bytes are stored, and rx_full is 1 exactly when 16 bytes are stored. Both are registered and valid one clock after the push or pop.
- R9: A flush empties the FIFO and clears rx_overflow, and it takes priority over any push or read in the same cycle. host_rdata holds during a flush cycle, and the threshold is kept.
- R10: A push and a data read in the same cycle, with the FIFO neither empty nor full, both take effect and leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Byte engine offers a received byte |
| push_data | input | 8 | Received byte |
| flush | input | 1 | Synchronous discard of all stored bytes |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | 0 data, 1 fill level, 2 threshold, 3 reserved |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| rx_empty | output | 1 | FIFO holds no byte |
| rx_full | output | 1 | FIFO holds 16 bytes |
| rx_level_irq | output | 1 | Stored count exceeds threshold |
| rx_overflow | output | 1 | Sticky: a byte was dropped |

## Verification
On every cycle, the assertions check the following: the two flags are never both set; a full FIFO always asserts the interrupt and an empty one never does; a push against a full FIFO sets the sticky overflow, which then persists; a flush leaves the FIFO empty with overflow cleared; and an empty-FIFO data read leaves host_rdata unchanged. Data ordering, the zero-based fill-level value, threshold read-back, and the exact threshold crossing need a model of the stored bytes. The bench's directed and random scenarios check these against its own queue model.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [1:0] {
    RXQ_DATA  = 2'd0,
    RXQ_LEVEL = 2'd1,
    RXQ_THR   = 2'd2,
    RXQ_RSV   = 2'd3
  } rxq_addr_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] head_data
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  // write port only, no reset, so the array maps to RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  assign head_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_en) wptr <= wptr + 1'b1;
      if (rd_en) rptr <= rptr + 1'b1;
    end
  end
endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
  parameter int DEPTH = 16,
  parameter int TW    = $clog2(DEPTH),
  parameter int CW    = TW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          thr_wr,
  input  logic [TW-1:0] thr_wdata,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [CW-1:0] count,
  output logic [TW-1:0] thr,
  output logic          empty_q,
  output logic          full_q,
  output logic          irq_q,
  output logic          ovf_q
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] count_n;
  logic [TW-1:0] thr_n;
  logic          ovf_n;

  always_comb begin
    push_ok = push_req && !flush && (count != FULL_CNT);
    pop_ok  = pop_req  && !flush && (count != '0);
    if (flush) begin
      count_n = '0;
    end else begin
      case ({push_ok, pop_ok})
        2'b10:   count_n = count + 1'b1;
        2'b01:   count_n = count - 1'b1;
        default: count_n = count;
      endcase
    end
    thr_n = thr_wr ? thr_wdata : thr;
    ovf_n = flush ? 1'b0 : (ovf_q || (push_req && count == FULL_CNT));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      thr     <= '0;
      ovf_q   <= 1'b0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      count   <= count_n;
      thr     <= thr_n;
      ovf_q   <= ovf_n;
      empty_q <= (count_n == '0);
      full_q  <= (count_n == FULL_CNT);
      irq_q   <= (count_n > {1'b0, thr_n});
    end
  end
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  input  logic          flush,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [1:0]    host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          rx_empty,
  output logic          rx_full,
  output logic          rx_level_irq,
  output logic          rx_overflow
);
  localparam int TW = $clog2(DEPTH);
  localparam int CW = TW + 1;

  rxq_addr_e     addr;
  logic          push_ok, pop_ok, pop_req, thr_wr;
  logic [CW-1:0] count;
  logic [TW-1:0] thr, level_zb;
  logic [DW-1:0] head_data;

  assign addr    = rxq_addr_e'(host_addr);
  assign pop_req = host_rd && (addr == RXQ_DATA);
  assign thr_wr  = host_wr && (addr == RXQ_THR);

  rxq_level #(.DEPTH(DEPTH), .TW(TW), .CW(CW)) u_level (
    .clk(clk), .rst(rst), .flush(flush),
    .push_req(push_valid), .pop_req(pop_req),
    .thr_wr(thr_wr), .thr_wdata(host_wdata[TW-1:0]),
    .push_ok(push_ok), .pop_ok(pop_ok),
    .count(count), .thr(thr),
    .empty_q(rx_empty), .full_q(rx_full),
    .irq_q(rx_level_irq), .ovf_q(rx_overflow)
  );

  rxq_store #(.DW(DW), .DEPTH(DEPTH), .AW(TW)) u_store (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_en(push_ok), .wr_data(push_data),
    .rd_en(pop_ok), .head_data(head_data)
  );

  // zero-based fill level, saturating at zero when empty
  assign level_zb = (count == '0) ? '0 : TW'(count - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (host_rd && !flush) begin
      case (addr)
        RXQ_DATA:  if (pop_ok) host_rdata <= head_data;
        RXQ_LEVEL: host_rdata <= {{(DW-TW){1'b0}}, level_zb};
        RXQ_THR:   host_rdata <= {{(DW-TW){1'b0}}, thr};
        default:   host_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          push_valid,
  input logic          flush,
  input logic          host_rd,
  input logic [1:0]    host_addr,
  input logic [DW-1:0] host_rdata,
  input logic          rx_empty,
  input logic          rx_full,
  input logic          rx_level_irq,
  input logic          rx_overflow
);
  p_flags_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(rx_empty && rx_full));

  p_full_irq_r7: assert property (@(posedge clk) disable iff (rst)
    rx_full |-> rx_level_irq);

  p_empty_noirq_r7: assert property (@(posedge clk) disable iff (rst)
    rx_empty |-> !rx_level_irq);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (rx_full && push_valid && !flush) |=> rx_overflow);

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (rx_overflow && !flush) |=> rx_overflow);

  p_flush_clear_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (rx_empty && !rx_overflow));

  p_empty_read_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_empty && host_rd && host_addr == 2'd0 && !flush) |=> $stable(host_rdata));
endmodule

bind rxq_top rxq_chk #(.DW(DW)) u_rxq_chk (
  .clk(clk), .rst(rst), .push_valid(push_valid), .flush(flush),
  .host_rd(host_rd), .host_addr(host_addr), .host_rdata(host_rdata),
  .rx_empty(rx_empty), .rx_full(rx_full),
  .rx_level_irq(rx_level_irq), .rx_overflow(rx_overflow)
);

// File: tb/test_rxq_top.sv
module test_rxq_top;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       push_valid = 1'b0;
  logic [7:0] push_data = '0;
  logic       flush = 1'b0;
  logic       host_rd = 1'b0;
  logic       host_wr = 1'b0;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       rx_empty, rx_full, rx_level_irq, rx_overflow;

  always #4 clk = ~clk;

  rxq_top i_rxq_top (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
    .flush(flush), .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .rx_empty(rx_empty),
    .rx_full(rx_full), .rx_level_irq(rx_level_irq), .rx_overflow(rx_overflow)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference model
  logic [7:0] mq[$];
  logic [3:0] m_thr = '0;
  logic       m_ovf = 1'b0;
  logic [7:0] m_rd  = '0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [1:0] a);
    int cnt = mq.size();
    case (a)
      2'd0: return (cnt > 0) ? mq[0] : m_rd;
      2'd1: return (cnt == 0) ? 8'd0 : 8'(cnt - 1);
      2'd2: return {4'd0, m_thr};
      default: return 8'd0;
    endcase
  endfunction

  task automatic model_cycle(input logic p, input logic [7:0] pd, input logic r,
                             input logic w, input logic [1:0] a,
                             input logic [7:0] wd, input logic f);
    int cnt = mq.size();
    if (f) begin
      mq.delete();
      m_ovf = 1'b0;
    end else begin
      if (r) m_rd = model_read(a);
      if (r && a == 2'd0 && cnt > 0) void'(mq.pop_front());
      if (p && cnt < DEPTH) mq.push_back(pd);
      if (p && cnt == DEPTH) m_ovf = 1'b1;
    end
    if (w && a == 2'd2) m_thr = wd[3:0];
  endtask

  task automatic check_all(input string tag);
    int cnt = mq.size();
    chk(tag, "R2/R5/R6 host_rdata", int'(host_rdata), int'(m_rd));
    chk(tag, "R8 rx_empty", int'(rx_empty), int'(cnt == 0));
    chk(tag, "R8 rx_full", int'(rx_full), int'(cnt == DEPTH));
    chk(tag, "R7 rx_level_irq", int'(rx_level_irq), int'(cnt > int'(m_thr)));
    chk(tag, "R3 rx_overflow", int'(rx_overflow), int'(m_ovf));
  endtask

  // drive at negedge, let one rising edge pass, check at the next negedge
  task automatic step(input string tag, input logic p, input logic [7:0] pd,
                      input logic r, input logic w, input logic [1:0] a,
                      input logic [7:0] wd, input logic f);
    push_valid = p; push_data = pd; host_rd = r; host_wr = w;
    host_addr = a; host_wdata = wd; flush = f;
    @(posedge clk);
    model_cycle(p, pd, r, w, a, wd, f);
    @(negedge clk);
    push_valid = 0; host_rd = 0; host_wr = 0; flush = 0;
    check_all(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check_all("R1 reset");
    step("R1 level read", 0, 0, 1, 0, 2'd1, 0, 0);
    step("R1 thr read",   0, 0, 1, 0, 2'd2, 0, 0);

    // R2 R8 fill to full
    for (int i = 0; i < DEPTH; i++) step("R2 fill", 1, 8'hA0 + 8'(i), 0, 0, 0, 0, 0);
    step("R5 level full", 0, 0, 1, 0, 2'd1, 0, 0);
    // R3 push while full, with simultaneous pop
    step("R3 drop full", 1, 8'h55, 0, 0, 0, 0, 0);
    step("R3 drop with pop", 1, 8'h66, 1, 0, 2'd0, 0, 0);
    // drain, R2 order, R3 sticky
    for (int i = 0; i < DEPTH; i++) step("R2 drain", 0, 0, 1, 0, 2'd0, 0, 0);
    // R4 read while empty
    step("R4 empty pop", 0, 0, 1, 0, 2'd0, 0, 0);
    step("R4 empty pop again", 0, 0, 1, 0, 2'd0, 0, 0);
    step("R5 level empty", 0, 0, 1, 0, 2'd1, 0, 0);
    // R9 flush clears overflow, beats push and read
    step("R9 flush", 1, 8'h12, 1, 0, 2'd0, 0, 1);

    // R6 R7 threshold crossing
    step("R6 thr write", 0, 0, 0, 1, 2'd2, 8'hF3, 0);
    step("R6 thr read", 0, 0, 1, 0, 2'd2, 0, 0);
    step("R6 reserved read", 0, 0, 1, 0, 2'd3, 0, 0);
    for (int i = 0; i < 4; i++) step("R7 crossing", 1, 8'(i + 1), 0, 0, 0, 0, 0);
    step("R7 thr raise", 0, 0, 0, 1, 2'd2, 8'd15, 0);
    step("R7 thr lower", 0, 0, 0, 1, 2'd2, 8'd0, 0);
    // R10 push and pop together
    step("R10 push+pop", 1, 8'h77, 1, 0, 2'd0, 0, 0);
    step("R10 level", 0, 0, 1, 0, 2'd1, 0, 0);
    // R9 flush keeps threshold
    step("R9 flush thr", 0, 0, 0, 0, 0, 0, 1);
    step("R9 thr kept", 0, 0, 1, 0, 2'd2, 0, 0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int sel = int'($urandom_range(0, 99));
      step("random",
           sel < 55,
           8'($urandom),
           ($urandom_range(0, 99) < 45),
           (sel >= 92),
           2'($urandom_range(0, 3)) & ((sel % 3 == 0) ? 2'd3 : 2'd0),
           8'($urandom),
           (sel == 99));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule